// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

The block multiplies two 32-bit binary floating-point words and returns their product in the same format. Each word carries a sign bit, an 8-bit biased exponent with a bias of 127, and a 23-bit fraction. For finite nonzero operands the block restores the hidden leading one. It forms the 48-bit integer product of the two significands and re-biases the sum of the exponents. It then shifts the product by at most one place to normalize it, and rounds to nearest, with ties going to the even value. The rounding uses a guard bit, a round bit and a sticky bit.

Zero, infinity and not-a-number operands are decoded before any arithmetic. A word whose exponent field is zero counts as zero, so denormal inputs are flushed. The block takes one operand pair per clock when `in_valid` is high. Each result appears two clocks later, with an overflow or underflow flag when the exponent leaves the representable range.

Top module: `fpm_mul_top`

## Requirements
- R1: A result is presented with `out_valid` high exactly two rising clock edges after its operands are accepted with `in_valid` high. Operands may arrive on consecutive cycles, and results leave in the order the operands arrived.
- R2: Except for the quiet NaN output, bit 31 of the result is the XOR of bit 31 of both operands.
- R3: For finite nonzero operands, the exponent field (bits 30:23) is E1 + E2 - 127, plus one when the significand product is 2.0 or more. The fraction field (bits 22:0) holds the normalized product with the hidden one removed.
- R4: Rounding is to nearest with ties to even. The 23-bit fraction is incremented when the guard bit is 1 and at least one of the following is 1: the round bit, the sticky bit (OR of all lower bits), or the fraction's least significant bit.
- R5: When the rounding increment carries out of the fraction, the fraction becomes zero and the exponent increases by one.
- R6: When the final biased exponent is 255 or more, the result is infinity (exponent field all ones, fraction zero) with the computed sign, `overflow` is 1 and `underflow` is 0.
- R7: When the final biased exponent is 0 or less, the result is zero with the computed sign, `underflow` is 1 and `overflow` is 0. An exponent field of 1 is still a normal result without a flag.
- R8: An operand with a zero exponent field is treated as zero, whether its fraction is zero or not. Its product with any finite value is zero with the XOR sign, and both flags are 0.
- R9: Infinity times a nonzero finite value or infinity gives infinity with the XOR sign, and both flags are 0.
- R10: When either operand is a NaN (exponent field 255, fraction nonzero), or when infinity meets zero, the result is 0x7FC00000 and both flags are 0.
- R11: During and after reset, `out_valid`, `overflow` and `underflow` are 0. Both flags are 0 in every cycle where `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair present this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| out_valid | output | 1 | Result present this cycle |
| result | output | 32 | Product |
| overflow | output | 1 | Product exponent too large, result forced to infinity |
| underflow | output | 1 | Product exponent too small, result forced to zero |

## Verification
The bound checker watches the following on every cycle:
- the two-cycle latency of `out_valid`;
- that the flags are silent when no result is presented;
- that the two flags are mutually exclusive;
- that an overflow always comes with an infinity and an underflow always with a zero;
- that the output sign follows the operand signs;
- that any NaN input yields the quiet NaN.

Only the bench's directed scenarios can show that the arithmetic itself is right. These cover exponent re-biasing, the one-place normalization, the exact tie and above-half rounding cases, a rounding carry that crosses into the next binade or into overflow, and the decoding of flushed denormals, zeros and infinities.

// File: rtl/fpm_pkg.sv
// Package: shared operand classification for the floating-point multiplier.
// Assumes: denormal encodings are folded into the zero class by the decoder.
package fpm_pkg;
    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_NORM = 2'd1,
        CLS_INF  = 2'd2,
        CLS_NAN  = 2'd3
    } fpm_class_e;
endpackage

// File: rtl/fpm_decode.sv
// Operand decoder: splits a floating-point word into sign, class, biased
// exponent and significand with the hidden one restored.
// Assumes: an exponent field of zero means zero (denormals are flushed).
module fpm_decode
    import fpm_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W  = 1 + EXP_W + FRAC_W,
    localparam int MW = FRAC_W + 1
) (
    input  logic [W-1:0]     op,
    output logic             sign,
    output fpm_class_e       cls,
    output logic [EXP_W-1:0] exp,
    output logic [MW-1:0]    mant
);
    logic [FRAC_W-1:0] frac;

    // Field split and hidden-bit restoration.
    always_comb begin
        sign = op[W-1];
        exp  = op[W-2 -: EXP_W];
        frac = op[FRAC_W-1:0];
        mant = {1'b1, frac};
    end

    // Classification of the special encodings.
    always_comb begin
        if (&exp)
            cls = (|frac) ? CLS_NAN : CLS_INF;
        else if (exp == '0)
            cls = CLS_ZERO;
        else
            cls = CLS_NORM;
    end
endmodule

// File: rtl/fpm_round.sv
// Normalize-and-round unit: takes the raw significand product and the
// re-biased exponent, and returns the packed magnitude with range flags.
// Assumes: both significands had their hidden one set, so the product lies in [1,4).
module fpm_round #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int MW = FRAC_W + 1,
    localparam int PW = 2 * MW,
    localparam int XW = EXP_W + 2
) (
    input  logic [PW-1:0]          prod,
    input  logic signed [XW-1:0]   exp_in,
    output logic [EXP_W+FRAC_W-1:0] mag,
    output logic                   ovf,
    output logic                   unf
);
    localparam logic signed [XW-1:0] EXP_TOP = XW'((1 << EXP_W) - 1);

    logic                  top;
    logic [PW-2:0]         norm;
    logic [FRAC_W-1:0]     frac_n;
    logic                  g_bit, r_bit, s_bit, inc;
    logic [FRAC_W:0]       sum;
    logic signed [XW-1:0]  exp_n, exp_r;

    // One-place normalization and extraction of guard, round and sticky.
    always_comb begin
        top    = prod[PW-1];
        norm   = top ? prod[PW-2:0] : {prod[PW-3:0], 1'b0};
        frac_n = norm[PW-2 -: FRAC_W];
        g_bit  = norm[PW-2-FRAC_W];
        r_bit  = norm[PW-3-FRAC_W];
        s_bit  = |norm[PW-4-FRAC_W:0];
        exp_n  = exp_in + $signed({{(XW-1){1'b0}}, top});
    end

    // Round to nearest even, renormalize on carry, then range check.
    always_comb begin
        inc   = g_bit & (r_bit | s_bit | frac_n[0]);
        sum   = {1'b0, frac_n} + {{FRAC_W{1'b0}}, inc};
        exp_r = exp_n + $signed({{(XW-1){1'b0}}, sum[FRAC_W]});
        ovf   = (exp_r >= EXP_TOP);
        unf   = (exp_r <= $signed(XW'(0)));
        if (ovf)
            mag = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        else if (unf)
            mag = '0;
        else
            mag = {exp_r[EXP_W-1:0], sum[FRAC_W-1:0]};
    end
endmodule

// File: rtl/fpm_mul_top.sv
// Two-stage floating-point multiplier. Stage one decodes both operands,
// resolves the special cases, multiplies the significands and re-biases the
// exponent. Stage two normalizes, rounds and registers the result and flags.
// Assumes: round to nearest even only; denormals read as zero.
module fpm_mul_top
    import fpm_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W    = 1 + EXP_W + FRAC_W,
    localparam int MW   = FRAC_W + 1,
    localparam int PW   = 2 * MW,
    localparam int XW   = EXP_W + 2,
    localparam int BIAS = (1 << (EXP_W - 1)) - 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         out_valid,
    output logic [W-1:0] result,
    output logic         overflow,
    output logic         underflow
);
    localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic signed [XW-1:0] BIAS_S = XW'(BIAS);

    logic [W-1:0]     ops    [2];
    logic             sgn_v  [2];
    fpm_class_e       cls_v  [2];
    logic [EXP_W-1:0] exp_v  [2];
    logic [MW-1:0]    mant_v [2];

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    for (genvar gi = 0; gi < 2; gi++) begin : g_dec
        fpm_decode #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dec (
            .op   (ops[gi]),
            .sign (sgn_v[gi]),
            .cls  (cls_v[gi]),
            .exp  (exp_v[gi]),
            .mant (mant_v[gi])
        );
    end

    logic                 c_sign, any_nan, any_inf, any_zero, c_special;
    logic [W-1:0]         c_word;
    logic signed [XW-1:0] c_exp;
    logic [PW-1:0]        c_prod;

    // Special-case resolution, exponent re-bias and significand product.
    always_comb begin
        c_sign    = sgn_v[0] ^ sgn_v[1];
        any_nan   = (cls_v[0] == CLS_NAN)  || (cls_v[1] == CLS_NAN);
        any_inf   = (cls_v[0] == CLS_INF)  || (cls_v[1] == CLS_INF);
        any_zero  = (cls_v[0] == CLS_ZERO) || (cls_v[1] == CLS_ZERO);
        c_special = any_nan || any_inf || any_zero;
        if (any_nan || (any_inf && any_zero))
            c_word = QNAN;
        else if (any_inf)
            c_word = {c_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        else
            c_word = {c_sign, {(W-1){1'b0}}};
        c_exp  = $signed({2'b00, exp_v[0]}) + $signed({2'b00, exp_v[1]}) - BIAS_S;
        c_prod = {{MW{1'b0}}, mant_v[0]} * {{MW{1'b0}}, mant_v[1]};
    end

    logic                 s1_valid, s1_special, s1_sign;
    logic [W-1:0]         s1_word;
    logic signed [XW-1:0] s1_exp;
    logic [PW-1:0]        s1_prod;

    // Stage-one pipeline register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid   <= 1'b0;
            s1_special <= 1'b0;
            s1_sign    <= 1'b0;
            s1_word    <= '0;
            s1_exp     <= '0;
            s1_prod    <= '0;
        end else begin
            s1_valid   <= in_valid;
            s1_special <= c_special;
            s1_sign    <= c_sign;
            s1_word    <= c_word;
            s1_exp     <= c_exp;
            s1_prod    <= c_prod;
        end
    end

    logic [W-2:0] r_mag;
    logic         r_ovf, r_unf;

    fpm_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
        .prod   (s1_prod),
        .exp_in (s1_exp),
        .mag    (r_mag),
        .ovf    (r_ovf),
        .unf    (r_unf)
    );

    // Output register: selects the special word or the rounded product.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            overflow  <= 1'b0;
            underflow <= 1'b0;
        end else begin
            out_valid <= s1_valid;
            result    <= s1_special ? s1_word : {s1_sign, r_mag};
            overflow  <= s1_valid && !s1_special && r_ovf;
            underflow <= s1_valid && !s1_special && r_unf;
        end
    end
endmodule

// File: rtl/fpm_mul_chk.sv
// Checker for the floating-point multiplier: tracks operand sign and NaN
// status over the two-stage latency and checks the outputs against them.
// Assumes: attached to fpm_mul_top through the bind at the end of this file.
module fpm_mul_chk #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W = 1 + EXP_W + FRAC_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic         out_valid,
    input logic [W-1:0] result,
    input logic         overflow,
    input logic         underflow
);
    localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic nan_a, nan_b;
    logic [1:0] sgn_d, nan_d;

    // NaN detection on the raw operands.
    always_comb begin
        nan_a = (&op_a[W-2 -: EXP_W]) && (|op_a[FRAC_W-1:0]);
        nan_b = (&op_b[W-2 -: EXP_W]) && (|op_b[FRAC_W-1:0]);
    end

    // Delay line matching the design latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sgn_d <= '0;
            nan_d <= '0;
        end else begin
            sgn_d <= {sgn_d[0], op_a[W-1] ^ op_b[W-1]};
            nan_d <= {nan_d[0], nan_a || nan_b};
        end
    end

    AST_LATENCY_HI: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid); // R1
    AST_LATENCY_LO: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid); // R1
    AST_SIGN_XOR: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && result != QNAN) |-> result[W-1] == sgn_d[1]); // R2
    AST_OVF_INF: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> result[W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}); // R6
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(overflow && underflow)); // R6
    AST_UNF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> result[W-2:0] == '0); // R7
    AST_NAN_PROP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && nan_d[1]) |-> (result == QNAN && !overflow && !underflow)); // R10
    AST_FLAGS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!overflow && !underflow)); // R11
endmodule

bind fpm_mul_top fpm_mul_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .result    (result),
    .overflow  (overflow),
    .underflow (underflow)
);

// File: tb/fpm_mul_top_tb_top.sv
// Scoreboard bench: the driver queues expected words, the monitor pops them
// as results appear and checks value, flags and latency.
module fpm_mul_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        out_valid;
    logic [31:0] result;
    logic        overflow;
    logic        underflow;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [33:0] exp_q[$];
    string       tag_q[$];
    int          cyc_q[$];

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    fpm_mul_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_a      (op_a),
        .op_b      (op_b),
        .out_valid (out_valid),
        .result    (result),
        .overflow  (overflow),
        .underflow (underflow)
    );

    // Present one operand pair and queue its expected {result, ovf, unf}.
    task automatic drive(input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] res, input logic ovf,
                         input logic unf, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        op_a = a;
        op_b = b;
        exp_q.push_back({res, ovf, unf});
        tag_q.push_back(tag);
        cyc_q.push_back(cyc);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: compare each presented result against the queue head.
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    checks++;
                    failures++;
                    $display("FAIL R1 unexpected result actual=%h expected=none", result);
                end else begin
                    logic [33:0] e;
                    string t;
                    int c0;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    c0 = cyc_q.pop_front();
                    checks++;
                    if ({result, overflow, underflow} !== e) begin
                        failures++;
                        $display("FAIL %s actual=%h/%b%b expected=%h/%b%b", t,
                                 result, overflow, underflow, e[33:2], e[1], e[0]);
                    end
                    checks++;
                    if (cyc - c0 != 2) begin
                        failures++;
                        $display("FAIL R1 latency actual=%0d expected=2", cyc - c0);
                    end
                end
            end else if (overflow || underflow) begin
                checks++;
                failures++;
                $display("FAIL R11 flags while idle actual=%b%b expected=00", overflow, underflow);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || overflow !== 1'b0 || underflow !== 1'b0) begin
            failures++;
            $display("FAIL R11 reset actual=%b%b%b expected=000", out_valid, overflow, underflow);
        end
        rst_n = 1'b1;
        idle(2);
        // R3 exponent re-bias and one-place normalization
        drive(32'h3F800000, 32'h3F800000, 32'h3F800000, 0, 0, "R3 1*1");
        drive(32'h3FC00000, 32'h40000000, 32'h40400000, 0, 0, "R3 1.5*2");
        drive(32'h40000000, 32'h40400000, 32'h40C00000, 0, 0, "R3 2*3");
        drive(32'h3FC00000, 32'h3FC00000, 32'h40100000, 0, 0, "R3 1.5*1.5 shift");
        idle(1);
        // R2 sign
        drive(32'hC0C00000, 32'h40C00000, 32'hC2100000, 0, 0, "R2 -6*6");
        drive(32'hC0000000, 32'hC0400000, 32'h40C00000, 0, 0, "R2 -2*-3");
        idle(3);
        // R4 rounding
        drive(32'h3F800001, 32'h3FC00000, 32'h3FC00002, 0, 0, "R4 tie odd up");
        drive(32'h3F800003, 32'h3FC00000, 32'h3FC00004, 0, 0, "R4 tie even kept");
        drive(32'h3F800001, 32'h3FC00001, 32'h3FC00003, 0, 0, "R4 above half up");
        drive(32'h3F800001, 32'h3F800001, 32'h3F800002, 0, 0, "R4 below half down");
        // R5 rounding carry
        drive(32'h3FFFFFFE, 32'h3F800001, 32'h40000000, 0, 0, "R5 carry to 2.0");
        // R6 overflow
        drive(32'h7F000000, 32'h40000000, 32'h7F800000, 1, 0, "R6 overflow pos");
        drive(32'hFF000000, 32'h40000000, 32'hFF800000, 1, 0, "R6 overflow neg");
        drive(32'h7F7FFFFE, 32'h3F800001, 32'h7F800000, 1, 0, "R6 overflow by carry");
        idle(2);
        // R7 underflow
        drive(32'h00800000, 32'h3F000000, 32'h00000000, 0, 1, "R7 underflow pos");
        drive(32'h80800000, 32'h3F000000, 32'h80000000, 0, 1, "R7 underflow neg");
        drive(32'h00800000, 32'h00800000, 32'h00000000, 0, 1, "R7 deep underflow");
        drive(32'h00800000, 32'h3F800000, 32'h00800000, 0, 0, "R7 smallest normal");
        // R8 zero and flushed denormal
        drive(32'h00000000, 32'h40400000, 32'h00000000, 0, 0, "R8 +0*3");
        drive(32'h80000000, 32'h40400000, 32'h80000000, 0, 0, "R8 -0*3");
        drive(32'h00000001, 32'h3F800000, 32'h00000000, 0, 0, "R8 denorm*1");
        drive(32'h00000001, 32'hC0000000, 32'h80000000, 0, 0, "R8 denorm*-2");
        // R9 infinity
        drive(32'h7F800000, 32'h40000000, 32'h7F800000, 0, 0, "R9 inf*2");
        drive(32'hFF800000, 32'h40000000, 32'hFF800000, 0, 0, "R9 -inf*2");
        drive(32'h7F800000, 32'hFF800000, 32'hFF800000, 0, 0, "R9 inf*-inf");
        // R10 NaN and invalid
        drive(32'h7F800000, 32'h00000000, 32'h7FC00000, 0, 0, "R10 inf*0");
        drive(32'h7F800001, 32'h3F800000, 32'h7FC00000, 0, 0, "R10 nan*1");
        drive(32'hFFC00000, 32'h00000000, 32'h7FC00000, 0, 0, "R10 nan*0");
        drive(32'h00000001, 32'hFF800000, 32'h7FC00000, 0, 0, "R10 denorm*inf");
        idle(6);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R1 missing results actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule